// File: doc/BRIEF.md
# Serial Freeze-Enable Register

This block takes a one-wire serial stream, sampled on the rising edges of a free-running serial clock. It keeps a 12-bit vector of per-output run/freeze enables for a multi-bank clock generator. The line idles high. A frame opens with one low bit, and exactly twelve data bits follow it. The first data bit received is D0. Only a whole frame changes the stored settings. The stored vector then crosses into the output clock domain, where the divider and gating logic can use it.

The enables are split into a four-bit A bank, a four-bit B bank, a four-bit C bank and a sync-pulse enable. A feedback enable is also provided. Output C0 and the feedback output have no bit in the frame and always report enabled. A corrupted frame therefore can never stop the loop that keeps the system clocked. An active-low master reset returns every enable to 1 and puts the receiver back in its idle, start-hunting state.

Inside the block, completed frames move from the receiver to the holding register as a valid-only word stream. There is no ready signal, because a free-running serial line cannot be stalled. The holding register accepts every word in the cycle it is offered.

Top module: `frz_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, every enable output reads 1.
- R2: The receiver samples `sdata` on rising `sclk` edges. A high level while idle is ignored, and the first low bit sampled while idle starts a frame.
- R3: The twelve data bits after the start bit are D0 first through D11 last. D0..D3 drive `qa_en[0..3]`, D4..D7 drive `qb_en[0..3]`, D8..D10 drive `qc_en[1..3]`, and D11 drives `sync_en`.
- R4: A data bit of 0 makes its enable output 0 (frozen), and a data bit of 1 makes it 1 (running).
- R5: `qc_en[0]` and `fb_en` read 1 at all times, whatever frames are loaded.
- R6: The stored vector changes only once D11 of a frame has been sampled. A frame that has not been finished leaves the previous settings visible.
- R7: After D11 the receiver hunts for a new start bit at once. A start bit in the serial period that follows D11 begins the next frame.
- R8: A loaded vector reaches the outputs through a handshake in the `out_clk` domain. All enable bits change in the same `out_clk` cycle, no more than four `sclk` periods after D11 is sampled.
- R9: A reset during a frame discards the partial frame. Later idle-high bits do not change the all-ones state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Free-running serial clock; data sampled on rising edge |
| out_clk | input | 1 | Output-domain clock for the enable vector |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| sdata | input | 1 | Serial data, idles high |
| qa_en | output | 4 | A-bank enables |
| qb_en | output | 4 | B-bank enables |
| qc_en | output | 4 | C-bank enables, bit 0 fixed at 1 |
| sync_en | output | 1 | Sync-pulse output enable |
| fb_en | output | 1 | Feedback output enable, fixed at 1 |

## Verification
The bench walks a single zero through all twelve bit positions. A receiver that shifts in the wrong direction or miscounts shows a swapped bank or an off-by-one output. It stops the serial clock with eleven data bits received. A design that commits early shows the new settings while the frame is still open. It sends two frames with no idle bit between them. A receiver that wants a high bit before a new start loses or misaligns the second frame. It also resets in the middle of a frame. A design that keeps the partial shift state would then decode the idle-high bits that follow as a frame.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int FRAME_BITS  = 12;
  localparam int IDX_W       = $clog2(FRAME_BITS);
  localparam int QA_LSB      = 0;
  localparam int QA_N        = 4;
  localparam int QB_LSB      = 4;
  localparam int QB_N        = 4;
  localparam int QC_LSB      = 8;
  localparam int QC_FRZ_N    = 3;
  localparam int SYNC_BIT    = 11;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    RX_HUNT = 1'b0,
    RX_DATA = 1'b1
  } rx_state_t;
endpackage

// File: rtl/frz_rx.sv
module frz_rx
  import frz_pkg::*;
#(
  parameter int NB = FRAME_BITS,
  localparam int IW = $clog2(NB)
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          sdata,
  output logic          word_vld,
  output logic [NB-1:0] word,
  output logic          busy,
  output logic [IW-1:0] bit_idx
);
  rx_state_t     st;
  logic [NB-1:0] sh;
  logic [NB-1:0] word_nxt;
  logic          last_bit;

  assign last_bit = (bit_idx == IW'(NB - 1));
  assign busy     = (st == RX_DATA);

  always_comb begin
    word_nxt         = sh;
    word_nxt[NB-1]   = sdata;
  end

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= RX_HUNT;
      bit_idx  <= '0;
      sh       <= '0;
      word     <= '1;
      word_vld <= 1'b0;
    end else begin
      word_vld <= 1'b0;
      case (st)
        RX_HUNT: begin
          if (!sdata) begin
            st      <= RX_DATA;
            bit_idx <= '0;
          end
        end
        RX_DATA: begin
          sh[bit_idx] <= sdata;
          if (last_bit) begin
            word     <= word_nxt;
            word_vld <= 1'b1;
            st       <= RX_HUNT;
            bit_idx  <= '0;
          end else begin
            bit_idx <= bit_idx + 1'b1;
          end
        end
        default: st <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/frz_hold.sv
module frz_hold #(
  parameter int NB = 12
) (
  input  logic          sclk,
  input  logic          rst_n,
  input  logic          word_vld,
  input  logic [NB-1:0] word,
  output logic [NB-1:0] en_q,
  output logic          tog
);
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '1;
      tog  <= 1'b0;
    end else if (word_vld) begin
      en_q <= word;
      tog  <= ~tog;
    end
  end
endmodule

// File: rtl/frz_xfer.sv
module frz_xfer #(
  parameter int NB     = 12,
  parameter int STAGES = 2
) (
  input  logic          out_clk,
  input  logic          rst_n,
  input  logic          tog_in,
  input  logic [NB-1:0] vec_in,
  output logic          cap,
  output logic [NB-1:0] vec_out
);
  logic [STAGES-1:0] chain;
  logic              seen;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_sync
      always_ff @(posedge out_clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= 1'b0;
        else if (g == 0) chain[g] <= tog_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign cap = chain[STAGES-1] ^ seen;

  always_ff @(posedge out_clk or negedge rst_n) begin
    if (!rst_n) begin
      seen    <= 1'b0;
      vec_out <= '1;
    end else begin
      seen <= chain[STAGES-1];
      if (cap) vec_out <= vec_in;
    end
  end
endmodule

// File: rtl/frz_ctrl.sv
module frz_ctrl
  import frz_pkg::*;
(
  input  logic                sclk,
  input  logic                out_clk,
  input  logic                rst_n,
  input  logic                sdata,
  output logic [QA_N-1:0]     qa_en,
  output logic [QB_N-1:0]     qb_en,
  output logic [QC_FRZ_N:0]   qc_en,
  output logic                sync_en,
  output logic                fb_en
);
  logic                  word_vld;
  logic [FRAME_BITS-1:0] word;
  logic                  rx_busy;
  logic [IDX_W-1:0]      rx_idx;
  logic [FRAME_BITS-1:0] hold_vec;
  logic                  hold_tog;
  logic                  cap_stb;
  logic [FRAME_BITS-1:0] out_vec;

  frz_rx #(.NB(FRAME_BITS)) u_rx (
    .sclk(sclk), .rst_n(rst_n), .sdata(sdata),
    .word_vld(word_vld), .word(word), .busy(rx_busy), .bit_idx(rx_idx)
  );

  frz_hold #(.NB(FRAME_BITS)) u_hold (
    .sclk(sclk), .rst_n(rst_n), .word_vld(word_vld), .word(word),
    .en_q(hold_vec), .tog(hold_tog)
  );

  frz_xfer #(.NB(FRAME_BITS), .STAGES(SYNC_STAGES)) u_xfer (
    .out_clk(out_clk), .rst_n(rst_n), .tog_in(hold_tog), .vec_in(hold_vec),
    .cap(cap_stb), .vec_out(out_vec)
  );

  assign qa_en   = out_vec[QA_LSB +: QA_N];
  assign qb_en   = out_vec[QB_LSB +: QB_N];
  assign qc_en   = {out_vec[QC_LSB +: QC_FRZ_N], 1'b1};
  assign sync_en = out_vec[SYNC_BIT];
  assign fb_en   = 1'b1;
endmodule

// File: rtl/frz_ctrl_chk.sv
module frz_ctrl_chk
  import frz_pkg::*;
(
  input logic                  sclk,
  input logic                  out_clk,
  input logic                  rst_n,
  input logic                  sdata,
  input logic                  rx_busy,
  input logic [IDX_W-1:0]      rx_idx,
  input logic                  word_vld,
  input logic [FRAME_BITS-1:0] hold_vec,
  input logic                  cap_stb,
  input logic [FRAME_BITS-1:0] out_vec
);
  AST_START_DETECT: assert property (@(posedge sclk) disable iff (!rst_n)
    (!rx_busy && !sdata) |=> rx_busy); // R2

  AST_IDX_RANGE: assert property (@(posedge sclk) disable iff (!rst_n)
    rx_idx <= IDX_W'(FRAME_BITS - 1)); // R3

  AST_HOLD_ONLY_ON_FRAME: assert property (@(posedge sclk) disable iff (!rst_n)
    !word_vld |=> $stable(hold_vec)); // R6

  AST_VLD_REHUNT: assert property (@(posedge sclk) disable iff (!rst_n)
    word_vld |-> !rx_busy); // R7

  AST_OUT_STABLE: assert property (@(posedge out_clk) disable iff (!rst_n)
    !cap_stb |=> $stable(out_vec)); // R8

  AST_OUT_LOADS: assert property (@(posedge out_clk) disable iff (!rst_n)
    cap_stb |=> out_vec == $past(hold_vec)); // R8
endmodule

bind frz_ctrl frz_ctrl_chk u_chk (
  .sclk(sclk), .out_clk(out_clk), .rst_n(rst_n), .sdata(sdata),
  .rx_busy(rx_busy), .rx_idx(rx_idx), .word_vld(word_vld),
  .hold_vec(hold_vec), .cap_stb(cap_stb), .out_vec(out_vec)
);

// File: tb/sim_frz_ctrl.sv
module sim_frz_ctrl;
  logic       sclk = 1'b0;
  logic       out_clk = 1'b0;
  logic       sclk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       sdata = 1'b1;
  logic [3:0] qa_en, qb_en, qc_en;
  logic       sync_en, fb_en;
  int         n_chk = 0;
  int         n_err = 0;
  int         wd = 0;
  logic [11:0] cur;

  frz_ctrl u0 (
    .sclk(sclk), .out_clk(out_clk), .rst_n(rst_n), .sdata(sdata),
    .qa_en(qa_en), .qb_en(qb_en), .qc_en(qc_en), .sync_en(sync_en), .fb_en(fb_en)
  );

  initial forever begin #10; if (sclk_run) sclk = ~sclk; end
  initial forever #4 out_clk = ~out_clk;

  always @(posedge out_clk) begin
    wd <= wd + 1;
    if (wd == 100000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check_out(input logic [11:0] w, input string tag);
    logic [13:0] act, exp;
    act = {sync_en, qc_en, qb_en, qa_en, fb_en};
    exp = {w[11], w[10:8], 1'b1, w[7:4], w[3:0], 1'b1};
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    @(negedge sclk);
    sdata = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive_bit(1'b1);
  endtask

  task automatic send_bits(input logic [11:0] w);
    drive_bit(1'b0);
    for (int i = 0; i < 12; i++) drive_bit(w[i]);
  endtask

  task automatic load(input logic [11:0] w, input string tag);
    send_bits(w);
    idle(4);
    cur = w;
    check_out(w, tag);
  endtask

  // R1 R2: reset value and idle-high ignored
  task automatic t_reset;
    repeat (3) @(negedge sclk);
    check_out(12'hFFF, "R1 during reset");
    rst_n = 1'b1;
    idle(20);
    check_out(12'hFFF, "R1 R2 after release, idle high");
    cur = 12'hFFF;
  endtask

  // R3 R4 R5: walking zero and full patterns
  task automatic t_map;
    for (int i = 0; i < 12; i++) load(~(12'h1 << i), "R3 walking zero");
    load(12'h000, "R4 R5 all frozen");
    load(12'hA5C, "R3 R4 mixed pattern");
    load(12'hFFF, "R4 all enabled");
  endtask

  // R6: stop sclk with 11 data bits in, old value must remain
  task automatic t_partial;
    logic [11:0] w;
    w = 12'h3C6;
    load(12'h9A5, "R6 setup");
    drive_bit(1'b0);
    for (int i = 0; i < 11; i++) drive_bit(w[i]);
    @(negedge sclk);
    sclk_run = 1'b0;
    #300;
    check_out(12'h9A5, "R6 partial frame held");
    sdata = w[11];
    sclk_run = 1'b1;
    idle(4);
    check_out(w, "R6 completed after resume");
  endtask

  // R7: back-to-back frames with no idle bit
  task automatic t_b2b;
    send_bits(12'h0F0);
    send_bits(12'h50A);
    idle(4);
    check_out(12'h50A, "R7 back-to-back second frame");
  endtask

  // R8: latency bound after the last data bit
  task automatic t_latency;
    send_bits(12'h7E1);
    idle(3);
    check_out(12'h7E1, "R8 transfer latency");
    idle(2);
  endtask

  // R9: reset mid-frame
  task automatic t_midreset;
    load(12'h000, "R9 setup");
    drive_bit(1'b0);
    for (int i = 0; i < 5; i++) drive_bit(1'b0);
    @(negedge sclk);
    rst_n = 1'b0;
    #1;
    check_out(12'hFFF, "R1 R9 reset asserted mid-frame");
    repeat (2) @(negedge sclk);
    rst_n = 1'b1;
    sdata = 1'b1;
    idle(20);
    check_out(12'hFFF, "R9 partial frame discarded");
    load(12'h123, "R9 frame after reset");
  endtask

  initial begin
    t_reset;
    t_map;
    t_partial;
    t_b2b;
    t_latency;
    t_midreset;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule